// File: doc/BRIEF.md
# Receive Character Queue with Per-Character Error Status

This block buffers characters from a serial receiver until software reads them. Each stored entry holds the data byte and three error flags (break, framing, parity) that were captured when that character arrived. The flags of the oldest entry are visible before the byte is removed, so software reads the status first and then pops the data. A mode input can switch the status view to a sticky summary instead. In that mode the flags show the OR of every character accepted since the last clear-errors command.

The block also reports how many characters are stored, using an 8-bit code in which a full queue of 256 reads as zero. A receive-ready output asserts once the stored count reaches a programmable level. Characters arrive on a one-cycle write strobe. Reads are a one-cycle pop strobe, and the head data and flags are visible combinationally from registered state. Serial deserialization happens outside this block.

Top module: `rxq_status_fifo`

## Requirements
- R1: The queue holds up to 256 entries. Each entry is 11 bits: bit 10 is break, bit 9 is framing error, bit 8 is parity error and bits 7:0 are data. `rd_data` shows the data of the oldest entry, and characters leave in the order they arrived.
- R2: Stored data is masked by `char_len` at write time: 00 keeps 5 bits, 01 keeps 6, 10 keeps 7 and 11 keeps 8. The unused upper bits read as 0.
- R3: With `blk_mode`=0, `stat_flags` (bit 2 break, bit 1 framing, bit 0 parity) shows the flags of the head entry. It changes to the next entry's flags after a pop and reads 0 when the queue is empty.
- R4: With `blk_mode`=1, `stat_flags` is the OR of the flags of every accepted write since reset or since the last clear command (`cmd_valid` with `cmd_code`=0x04). Accumulation runs in both modes. A write accepted in the same cycle as the clear counts toward the new summary. Other command codes have no effect.
- R5: `fill_code` equals the stored count modulo 256, so 0 encodes both empty and full (256).
- R6: `rx_ready` is 1 exactly when the count is at least `lvl`. A `lvl` of 0 means 256, so a full queue always asserts `rx_ready` and an empty one never does.
- R7: A write while the count is 256 is dropped, even when a pop occurs in the same cycle, and it sets `overrun`. The clear command resets `overrun` unless a write is dropped in that same cycle.
- R8: A pop on an empty queue changes nothing. While the queue is empty, `rd_data` shows the data of the most recently popped entry.
- R9: A push and a pop in the same cycle with a count of 1 to 255 leave the count unchanged and keep the order. On an empty queue the pop is ignored and the push is stored.
- R10: After reset the queue is empty, `overrun` is 0, `stat_flags` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| char_len | input | 2 | Character length code for incoming data |
| wr_en | input | 1 | Store one received character |
| wr_data | input | 8 | Received character |
| wr_brk | input | 1 | Break detected on this character |
| wr_frm | input | 1 | Framing error on this character |
| wr_par | input | 1 | Parity error on this character |
| rd_pop | input | 1 | Remove the head entry |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code (0x04 clears errors) |
| blk_mode | input | 1 | 1 selects the accumulated status view |
| lvl | input | 8 | Service level, 0 means 256 |
| rd_data | output | 8 | Head data, or last popped data when empty |
| stat_flags | output | 3 | Break, framing, parity status |
| overrun | output | 1 | Sticky dropped-write flag |
| fill_code | output | 8 | Stored count modulo 256 |
| rx_ready | output | 1 | Count has reached the service level |

## Verification
A reference queue in the bench is driven by random bursts. Write-heavy bursts push the count to 256 and provoke drops, pop-heavy bursts drain the queue and pop it while empty, and balanced bursts exercise simultaneous push and pop in the middle of the range. The random error flags, together with toggling of the status mode, separate head-entry reporting from the sticky summary. Clear commands interleaved with other command codes show that only 0x04 resets the summary and the overrun flag. Directed cases cover each character length, the full-versus-empty ambiguity of the fill code, and a level of 0.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rxq_flags_t;

    localparam int          RXQ_DW          = 8;
    localparam int          RXQ_EW          = RXQ_DW + 3;
    localparam logic [7:0]  RXQ_CMD_CLR_ERR = 8'h04;

    function automatic logic [RXQ_DW-1:0] rxq_len_mask(input logic [1:0] len);
        logic [RXQ_DW-1:0] m;
        unique case (len)
            2'b00:   m = 8'h1F;
            2'b01:   m = 8'h3F;
            2'b10:   m = 8'h7F;
            default: m = 8'hFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int W  = 11,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          clr,
    input  logic [DW-1:0] head_data,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [AW:0]   count,
    output logic          accept,
    output logic          ovr,
    output logic [DW-1:0] last_data
);
    localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
        logic          ovr;
        logic [DW-1:0] last;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     full, empty, do_push, do_pop;

    always_comb begin
        full    = (st_q.cnt == FULL_CNT);
        empty   = (st_q.cnt == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        st_d    = st_q;
        if (do_push) begin
            st_d.wp = st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp   = st_q.rp + 1'b1;
            st_d.last = head_data;
        end
        unique case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        if (push && full) begin
            st_d.ovr = 1'b1;
        end else if (clr) begin
            st_d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wptr      = st_q.wp;
    assign rptr      = st_q.rp;
    assign count     = st_q.cnt;
    assign accept    = do_push;
    assign ovr       = st_q.ovr;
    assign last_data = st_q.last;
endmodule

// File: rtl/rxq_errs.sv
module rxq_errs
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       upd,
    input  rxq_flags_t flags_in,
    output rxq_flags_t acc
);
    typedef struct packed {
        rxq_flags_t acc;
    } errs_st_t;

    errs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.acc = '0;
        end
        if (upd) begin
            st_d.acc = st_d.acc | flags_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc = st_q.acc;
endmodule

// File: rtl/rxq_status_fifo.sv
module rxq_status_fifo
    import rxq_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    char_len,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          wr_brk,
    input  logic          wr_frm,
    input  logic          wr_par,
    input  logic          rd_pop,
    input  logic          cmd_valid,
    input  logic [7:0]    cmd_code,
    input  logic          blk_mode,
    input  logic [AW-1:0] lvl,
    output logic [7:0]    rd_data,
    output logic [2:0]    stat_flags,
    output logic          overrun,
    output logic [AW-1:0] fill_code,
    output logic          rx_ready
);
    localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};

    logic [AW-1:0]     wptr, rptr;
    logic [AW:0]       count;
    logic [AW:0]       thresh;
    logic              accept, clr, empty;
    logic [RXQ_DW-1:0] last_data, masked;
    logic [RXQ_EW-1:0] wr_entry, head_entry;
    rxq_flags_t        in_flags, head_flags, acc_flags;

    assign clr      = cmd_valid && (cmd_code == RXQ_CMD_CLR_ERR);
    assign masked   = wr_data & rxq_len_mask(char_len);
    assign in_flags = '{brk: wr_brk, frm: wr_frm, par: wr_par};
    assign wr_entry = {in_flags, masked};

    rxq_store #(.W(RXQ_EW), .AW(AW)) u_store (
        .clk   (clk),
        .we    (accept),
        .waddr (wptr),
        .wdata (wr_entry),
        .raddr (rptr),
        .rdata (head_entry)
    );

    rxq_ctrl #(.AW(AW), .DW(RXQ_DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .pop       (rd_pop),
        .clr       (clr),
        .head_data (head_entry[RXQ_DW-1:0]),
        .wptr      (wptr),
        .rptr      (rptr),
        .count     (count),
        .accept    (accept),
        .ovr       (overrun),
        .last_data (last_data)
    );

    rxq_errs u_errs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .upd      (accept),
        .flags_in (in_flags),
        .acc      (acc_flags)
    );

    always_comb begin
        empty      = (count == '0);
        head_flags = empty ? '0 : rxq_flags_t'(head_entry[RXQ_EW-1:RXQ_DW]);
        rd_data    = empty ? last_data : head_entry[RXQ_DW-1:0];
        stat_flags = blk_mode ? acc_flags : head_flags;
        thresh     = (lvl == '0) ? FULL_CNT : {1'b0, lvl};
        rx_ready   = (count >= thresh);
        fill_code  = count[AW-1:0];
    end
endmodule

// File: rtl/rxq_status_fifo_chk.sv
module rxq_status_fifo_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_pop,
    input logic          cmd_valid,
    input logic [7:0]    cmd_code,
    input logic          blk_mode,
    input logic [AW-1:0] lvl,
    input logic [7:0]    rd_data,
    input logic [2:0]    stat_flags,
    input logic          overrun,
    input logic [AW-1:0] fill_code,
    input logic          rx_ready
);
    logic is_full, is_empty, is_clr;

    assign is_full  = (fill_code == '0) && rx_ready;
    assign is_empty = (fill_code == '0) && !rx_ready;
    assign is_clr   = cmd_valid && (cmd_code == 8'h04);

    a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && wr_en && !rd_pop) |=> ((fill_code == '0) && overrun));

    a_r7_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (is_clr && !(is_full && wr_en)) |=> !overrun);

    a_r6_ready_level: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> ((fill_code == '0) || ((lvl != '0) && (fill_code >= lvl))));

    a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty && rd_pop && !wr_en) |=> ($stable(rd_data) && (fill_code == '0)));

    a_r9_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_pop && (fill_code != '0)) |=> (fill_code == $past(fill_code)));

    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_mode && !is_clr) |=>
            (!blk_mode || ((stat_flags & $past(stat_flags)) == $past(stat_flags))));

    a_r3_empty_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty && !blk_mode) |-> (stat_flags == 3'b000));
endmodule

bind rxq_status_fifo rxq_status_fifo_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_pop     (rd_pop),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .blk_mode   (blk_mode),
    .lvl        (lvl),
    .rd_data    (rd_data),
    .stat_flags (stat_flags),
    .overrun    (overrun),
    .fill_code  (fill_code),
    .rx_ready   (rx_ready)
);

// File: tb/test_rxq_status_fifo.sv
module test_rxq_status_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 8;
    localparam int DEPTH      = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    char_len = 2'b11;
    logic          wr_en = 1'b0, wr_brk = 1'b0, wr_frm = 1'b0, wr_par = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          rd_pop = 1'b0, cmd_valid = 1'b0, blk_mode = 1'b0;
    logic [7:0]    cmd_code = '0;
    logic [AW-1:0] lvl = 8'd1;
    logic [7:0]    rd_data;
    logic [2:0]    stat_flags;
    logic          overrun, rx_ready;
    logic [AW-1:0] fill_code;

    logic [10:0] mq[$];
    logic [7:0]  m_last = '0;
    logic [2:0]  m_acc = '0;
    logic        m_ovr = 1'b0;
    int          n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxq_status_fifo #(.AW(AW)) i_rxq_status_fifo (
        .clk(clk), .rst_n(rst_n), .char_len(char_len), .wr_en(wr_en),
        .wr_data(wr_data), .wr_brk(wr_brk), .wr_frm(wr_frm), .wr_par(wr_par),
        .rd_pop(rd_pop), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .blk_mode(blk_mode), .lvl(lvl), .rd_data(rd_data),
        .stat_flags(stat_flags), .overrun(overrun), .fill_code(fill_code),
        .rx_ready(rx_ready)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] len_mask(input logic [1:0] len);
        return (len == 2'b00) ? 8'h1F : (len == 2'b01) ? 8'h3F :
               (len == 2'b10) ? 8'h7F : 8'hFF;
    endfunction

    function automatic logic [7:0] exp_rd();
        return (mq.size() != 0) ? mq[0][7:0] : m_last;
    endfunction

    function automatic logic [2:0] exp_stat();
        if (blk_mode) return m_acc;
        return (mq.size() != 0) ? mq[0][10:8] : 3'b000;
    endfunction

    function automatic logic exp_ready();
        int thr = (lvl == '0) ? DEPTH : int'(lvl);
        return mq.size() >= thr;
    endfunction

    task automatic compare_all();
        chk("R1", "rd_data", rd_data, exp_rd());
        chk(blk_mode ? "R4" : "R3", "stat_flags", stat_flags, exp_stat());
        chk("R5", "fill_code", fill_code, mq.size() % DEPTH);
        chk("R6", "rx_ready", rx_ready, exp_ready());
        chk("R7", "overrun", overrun, m_ovr);
    endtask

    task automatic cycle(input logic w, input logic [7:0] d, input logic [2:0] f,
                         input logic [1:0] len, input logic p,
                         input logic cv, input logic [7:0] cc);
        logic full_now, push_ok, pop_ok, clr;
        @(negedge clk);
        wr_en = w; wr_data = d; {wr_brk, wr_frm, wr_par} = f; char_len = len;
        rd_pop = p; cmd_valid = cv; cmd_code = cc;
        full_now = (mq.size() == DEPTH);
        push_ok  = w && !full_now;
        pop_ok   = p && (mq.size() != 0);
        clr      = cv && (cc == 8'h04);
        m_acc    = (clr ? 3'b000 : m_acc) | (push_ok ? f : 3'b000);
        if (w && full_now) m_ovr = 1'b1;
        else if (clr)      m_ovr = 1'b0;
        if (pop_ok) begin
            m_last = mq[0][7:0];
            void'(mq.pop_front());
        end
        if (push_ok) mq.push_back({f, d & len_mask(len)});
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic cfg(input logic bm, input logic [AW-1:0] lv);
        @(negedge clk);
        wr_en = 1'b0; rd_pop = 1'b0; cmd_valid = 1'b0;
        blk_mode = bm; lvl = lv;
        @(posedge clk);
        #1;
        compare_all();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        chk("R10", "reset rd_data", rd_data, 0);
        chk("R10", "reset stat_flags", stat_flags, 0);
        chk("R10", "reset overrun", overrun, 0);
        chk("R10", "reset fill_code", fill_code, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: each character length masks the upper bits
        for (int l = 0; l < 4; l++) begin
            cycle(1'b1, 8'hFF, 3'b000, 2'(l), 1'b0, 1'b0, 8'h00);
            chk("R2", "masked data of first entry", rd_data, 8'h1F);
        end
        for (int l = 1; l < 4; l++) begin
            cycle(1'b0, 8'h00, 3'b000, 2'b11, 1'b1, 1'b0, 8'h00);
            chk("R2", "masked data after pop", rd_data, len_mask(2'(l)));
        end
        // R9: push and pop together with one entry stored
        cycle(1'b1, 8'hA5, 3'b101, 2'b11, 1'b1, 1'b0, 8'h00);
        chk("R9", "count kept on push+pop", fill_code, 1);
        chk("R9", "order kept on push+pop", rd_data, 8'hA5);
        // R8: pop the last entry, then pop empty
        cycle(1'b0, 8'h00, 3'b000, 2'b11, 1'b1, 1'b0, 8'h00);
        cycle(1'b0, 8'h00, 3'b000, 2'b11, 1'b1, 1'b0, 8'h00);
        chk("R8", "empty pop holds last data", rd_data, 8'hA5);
        chk("R8", "empty pop keeps count", fill_code, 0);
        // R9: push and pop on empty stores the push
        cycle(1'b1, 8'h3C, 3'b010, 2'b11, 1'b1, 1'b0, 8'h00);
        chk("R9", "empty push+pop stores", fill_code, 1);
        // R6/R7: fill to 256 with level 0
        cfg(1'b0, 8'd0);
        for (int i = 1; i < DEPTH; i++)
            cycle(1'b1, 8'(i), 3'(i), 2'b11, 1'b0, 1'b0, 8'h00);
        chk("R6", "full asserts ready at level 0", rx_ready, 1);
        chk("R5", "full encodes as 0", fill_code, 0);
        cycle(1'b1, 8'h77, 3'b111, 2'b11, 1'b1, 1'b0, 8'h00);
        chk("R7", "drop with pop in same cycle", fill_code, 255);
        chk("R7", "overrun set", overrun, 1);
        cycle(1'b0, 8'h00, 3'b000, 2'b11, 1'b0, 1'b1, 8'h05);
        chk("R4", "other command ignored", overrun, 1);
        cycle(1'b0, 8'h00, 3'b000, 2'b11, 1'b0, 1'b1, 8'h04);
        chk("R7", "clear resets overrun", overrun, 0);
        cfg(1'b1, 8'd16);
        cycle(1'b0, 8'h00, 3'b000, 2'b11, 1'b0, 1'b1, 8'h04);
        chk("R4", "clear empties summary", stat_flags, 0);

        // random bursts
        for (int i = 0; i < 4000; i++) begin
            int wp = (i < 1500) ? 75 : (i < 2800) ? 50 : 25;
            logic w = ($urandom % 100) < wp;
            logic p = ($urandom % 100) < (100 - wp);
            logic cv = ($urandom % 40) == 0;
            logic [7:0] cc = ($urandom % 2) ? 8'h04 : 8'($urandom);
            if (i % 500 == 250) cfg(~blk_mode, 8'($urandom));
            cycle(w, 8'($urandom), 3'(($urandom % 4 == 0) ? $urandom : 0),
                  2'($urandom), p, cv, cc);
        end
        while (mq.size() != 0)
            cycle(1'b0, 8'h00, 3'b000, 2'b11, 1'b1, 1'b0, 8'h00);
        chk("R8", "drained queue empty", fill_code, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule